// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one down-counting timer channel with an 8-bit register port toward a processor. Software writes a control byte to pick how the channel behaves, then writes a 16-bit start value as one or two bytes. The counter steps down once for every count-clock tick. A gate input can pause counting or start it, and one output line carries the result. The channel has three behaviours: an output that rises once when the count runs out and can serve as an interrupt, a one-shot pulse started again by each rising gate edge, and a rate generator that repeats forever.

A latch command copies the running count into a holding register. Software can then read it as two bytes while the counter keeps going. All logic runs on one system clock. The count clock arrives as a one-cycle `cntTick` enable. Bus strobes are active low and are sampled on each clock edge, so each access must be held for exactly one clock.

Top module: `tmr_channel`

## Requirements
- R1: A write with `a0`=1 is a control byte. It is accepted only when bits [7:6] are 00. A byte with access bits [5:4] = 00 is a latch command. Any other byte is a mode setting, and it is ignored unless bit [0] is 0 and bits [3:1] are 000 (terminal count), 001 (one-shot) or 010 (rate). An ignored byte changes neither the output nor the count.
- R2: An accepted mode setting drives the output to the mode's idle level: low for terminal count, high for one-shot and rate. The counter then stays idle until a full count has been written.
- R3: Access bits [5:4] select how count bytes are written with `a0`=0. The value 01 writes the low byte only, with the high byte taken as 0. The value 10 writes the high byte only, with the low byte taken as 0. The value 11 writes the low byte and then the high byte. A count of 0 acts as 65536.
- R4: In terminal-count mode, writing the last count byte loads the counter and drives the output low. The counter drops by one on each tick while the gate is high. The output rises on the Nth tick and stays high until a new count or mode setting is written.
- R5: In terminal-count and rate modes, a low gate holds the count. Counting resumes from the held value when the gate goes high again.
- R6: In rate mode with count N (N >= 2), the output is high except while the count is 1. It is low for exactly one tick period. The count then reloads, so the pattern repeats every N ticks.
- R7: In one-shot mode, writing the count does not start counting. A rising gate edge loads the count and drives the output low on the next clock. The output returns high on the Nth tick after that.
- R8: A rising gate edge during a one-shot pulse restarts it from the programmed count. A count written during a pulse does not change that pulse. It applies from the next trigger.
- R9: A latch command captures the count without disturbing counting. With access mode 11, reads return the held low byte and then the held high byte, and the latch is released after the second read. A latch command issued while a latch is still held is ignored.
- R10: A read with no latch held returns the live count, with bytes chosen by the access mode as for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | One-cycle count-clock enable |
| gate | input | 1 | Gate: enable level (modes 0, 2), trigger edge (mode 1) |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe |
| rdN | input | 1 | Active-low read strobe |
| a0 | input | 1 | 1 = control byte, 0 = count data |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data |
| outLine | output | 1 | Timer output |

## Verification
The assertions check these rules on every cycle:
- the idle output level after each accepted mode setting;
- a terminal-count output that stays high;
- a held count while the gate is low;
- the rate output rising again on the tick after its low;
- the one-shot output falling on a trigger;
- a count left untouched by a latch command.

Some behaviours can only be shown by the bench's scenarios, because they depend on what the bench has programmed:
- the exact tick on which each output edge occurs for random counts;
- the byte order of reads;
- a second latch that is ignored;
- zero acting as 65536;
- a count written mid-pulse that applies only from the next trigger.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    MODE_TC      = 3'd0,
    MODE_ONESHOT = 3'd1,
    MODE_RATE    = 3'd2
  } tmrMode_e;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } tmrAcc_e;

  // strobes from the control side to the counting datapath
  typedef struct packed {
    logic             setMode;
    tmrMode_e         mode;
    logic             loadCount;
    logic [CNT_W-1:0] loadVal;
    logic             latch;
  } tmrCmd_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              a0,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic [CNT_W-1:0]  liveCount,
  output tmrCmd_t           cmd,
  output logic [BYTE_W-1:0] dataOut
);
  logic              wrEv, rdEv, ctrlWr, dataWr, dataRd;
  logic              selOk, wordOk, isLatch;
  tmrAcc_e           accReg;
  logic              configured, hiNext, rdHi, latched;
  logic [BYTE_W-1:0] loHold;
  logic [CNT_W-1:0]  latchVal, readSrc;

  assign wrEv   = !csN && !wrN;
  assign rdEv   = !csN && !rdN && wrN;
  assign ctrlWr = wrEv && a0;
  assign dataWr = wrEv && !a0 && configured;
  assign dataRd = rdEv && !a0 && configured;

  assign selOk   = (dataIn[7:6] == 2'b00);
  assign isLatch = ctrlWr && selOk && (dataIn[5:4] == 2'b00);
  assign wordOk  = selOk && !dataIn[0] && (dataIn[3:1] <= 3'd2) && (dataIn[5:4] != 2'b00);

  always_comb begin
    cmd.setMode   = ctrlWr && wordOk;
    cmd.mode      = tmrMode_e'(dataIn[3:1]);
    cmd.latch     = isLatch && !latched;
    cmd.loadCount = 1'b0;
    cmd.loadVal   = '0;
    case (accReg)
      ACC_LO: begin
        cmd.loadCount = dataWr;
        cmd.loadVal   = {{BYTE_W{1'b0}}, dataIn};
      end
      ACC_HI: begin
        cmd.loadCount = dataWr;
        cmd.loadVal   = {dataIn, {BYTE_W{1'b0}}};
      end
      ACC_BOTH: begin
        cmd.loadCount = dataWr && hiNext;
        cmd.loadVal   = {dataIn, loHold};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg     <= ACC_BOTH;
      configured <= 1'b0;
      hiNext     <= 1'b0;
      rdHi       <= 1'b0;
      latched    <= 1'b0;
      loHold     <= '0;
      latchVal   <= '0;
    end else begin
      if (cmd.setMode) begin
        accReg     <= tmrAcc_e'(dataIn[5:4]);
        configured <= 1'b1;
        hiNext     <= 1'b0;
        rdHi       <= 1'b0;
      end else if (dataWr && accReg == ACC_BOTH) begin
        if (!hiNext) loHold <= dataIn;
        hiNext <= !hiNext;
      end
      if (cmd.latch) begin
        latchVal <= liveCount;
        latched  <= 1'b1;
        rdHi     <= 1'b0;
      end else if (dataRd) begin
        if (accReg == ACC_BOTH) begin
          rdHi <= !rdHi;
          if (rdHi) latched <= 1'b0;
        end else begin
          latched <= 1'b0;
        end
      end
    end
  end

  assign readSrc = latched ? latchVal : liveCount;

  always_comb begin
    case (accReg)
      ACC_HI:   dataOut = readSrc[CNT_W-1:BYTE_W];
      ACC_BOTH: dataOut = rdHi ? readSrc[CNT_W-1:BYTE_W] : readSrc[BYTE_W-1:0];
      default:  dataOut = readSrc[BYTE_W-1:0];
    endcase
  end
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrCmd_t          cmd,
  input  logic             cntTick,
  input  logic             gate,
  output logic [CNT_W-1:0] count,
  output tmrMode_e         modeOut,
  output logic             armedOut,
  output logic             outLine
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] reload;
  tmrMode_e         mode;
  logic             armed, active, outReg, gatePrev, trig, step;

  assign trig = gate && !gatePrev;
  assign step = cntTick && gate && armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      reload   <= '0;
      mode     <= MODE_TC;
      armed    <= 1'b0;
      active   <= 1'b0;
      outReg   <= 1'b0;
      gatePrev <= 1'b0;
    end else begin
      gatePrev <= gate;
      if (cmd.setMode) begin
        mode   <= cmd.mode;
        armed  <= 1'b0;
        active <= 1'b0;
        outReg <= (cmd.mode != MODE_TC);
      end else if (cmd.loadCount) begin
        reload <= cmd.loadVal;
        armed  <= 1'b1;
        if (mode == MODE_TC) begin
          count  <= cmd.loadVal;
          outReg <= 1'b0;
        end else if (mode == MODE_RATE) begin
          count  <= cmd.loadVal;
          outReg <= 1'b1;
        end
      end else begin
        case (mode)
          MODE_TC: if (step) begin
            count <= count - ONE;
            if (count == ONE) outReg <= 1'b1;
          end
          MODE_ONESHOT: begin
            if (trig && armed) begin
              count  <= reload;
              active <= 1'b1;
              outReg <= 1'b0;
            end else if (cntTick && active) begin
              count <= count - ONE;
              if (count == ONE) begin
                outReg <= 1'b1;
                active <= 1'b0;
              end
            end
          end
          MODE_RATE: if (step) begin
            if (count == ONE) begin
              count  <= reload;
              outReg <= 1'b1;
            end else begin
              count <= count - ONE;
              if (count == TWO) outReg <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign outLine  = outReg;
  assign modeOut  = mode;
  assign armedOut = armed;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntTick,
  input  logic              gate,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              a0,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [BYTE_W-1:0] dataOut,
  output logic              outLine
);
  tmrCmd_t          cmd;
  logic [CNT_W-1:0] count;
  tmrMode_e         curMode;
  logic             armed;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN), .a0(a0),
    .dataIn(dataIn), .liveCount(count), .cmd(cmd), .dataOut(dataOut)
  );

  tmr_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cntTick(cntTick), .gate(gate),
    .count(count), .modeOut(curMode), .armedOut(armed), .outLine(outLine)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cntTick,
  input logic             gate,
  input logic             outLine,
  input logic [CNT_W-1:0] count,
  input logic [2:0]       mode,
  input logic             armed,
  input logic             setMode,
  input logic [2:0]       newMode,
  input logic             loadCount,
  input logic             latchCmd
);
  logic quiet;
  assign quiet = !setMode && !loadCount;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    setMode |=> outLine == ($past(newMode) != 3'd0)); // R2

  AST_TC_OUT_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd0 && outLine && quiet) |=> outLine); // R4

  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 3'd1 && !gate && quiet) |=> $stable(count)); // R5

  AST_RATE_LOW_ONE_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd2 && armed && gate && cntTick && !outLine && quiet) |=> outLine); // R6

  AST_ONESHOT_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd1 && armed && $rose(gate) && quiet) |=> !outLine); // R7

  AST_LATCH_NO_DISTURB: assert property (@(posedge clk) disable iff (!rstN)
    (latchCmd && !cntTick) |=> $stable(count)); // R9
endmodule

bind tmr_channel tmr_channel_chk u_chk (
  .clk(clk), .rstN(rstN), .cntTick(cntTick), .gate(gate), .outLine(outLine),
  .count(count), .mode(curMode), .armed(armed), .setMode(cmd.setMode),
  .newMode(cmd.mode), .loadCount(cmd.loadCount), .latchCmd(cmd.latch)
);

// File: tb/tmr_channel_bench.sv
`timescale 1ns/1ps
module tmr_channel_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntTick = 1'b0;
  logic       gate = 1'b0;
  logic       csN = 1'b1, wrN = 1'b1, rdN = 1'b1, a0 = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       outLine;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_channel u_tmr_channel (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .gate(gate), .csN(csN),
    .wrN(wrN), .rdN(rdN), .a0(a0), .dataIn(dataIn), .dataOut(dataOut),
    .outLine(outLine)
  );

  function automatic int rateOut(input int k, input int n);
    return ((k % n) == n - 1) ? 0 : 1;
  endfunction

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic addr, input logic [7:0] b);
    @(negedge clk);
    a0 = addr; dataIn = b; csN = 1'b0; wrN = 1'b0;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic wrCtrl(input logic [7:0] b);
    busWrite(1'b1, b);
  endtask

  task automatic wrData(input logic [7:0] b);
    busWrite(1'b0, b);
  endtask

  task automatic readByte(output logic [7:0] b);
    @(negedge clk);
    a0 = 1'b0; csN = 1'b0; rdN = 1'b0;
    #1 b = dataOut;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic readWord(output logic [15:0] v);
    logic [7:0] lo, hi;
    readByte(lo);
    readByte(hi);
    v = {hi, lo};
  endtask

  task automatic latchRead(output logic [15:0] v);
    wrCtrl(8'h00);
    readWord(v);
  endtask

  task automatic doTick();
    @(negedge clk);
    cntTick = 1'b1;
    @(negedge clk);
    cntTick = 1'b0;
  endtask

  task automatic setGate(input logic g);
    @(negedge clk);
    gate = g;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    int n, m;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // terminal-count mode, random count, LSB then MSB
    gate = 1'b1;
    wrCtrl(8'h30);
    chkEq("R2 tc idle low", outLine, 0);
    n = 3 + int'($urandom % 38);
    wrData(n[7:0]); wrData(n[15:8]);
    for (int k = 1; k <= n; k++) begin
      doTick();
      chkEq("R4 tc output edge", outLine, (k == n) ? 1 : 0);
      if (k == 2) begin
        latchRead(v);
        chkEq("R9 latched count", {16'b0, v}, n - 2);
      end
    end
    for (int k = 0; k < 3; k++) begin
      doTick();
      chkEq("R4 tc stays high", outLine, 1);
    end

    // rejected control bytes: wrong select, bad mode, bit0 set
    wrCtrl(8'h70); chkEq("R1 select!=00 ignored", outLine, 1);
    wrCtrl(8'h3C); chkEq("R1 mode 110 ignored", outLine, 1);
    wrCtrl(8'h31); chkEq("R1 bit0 set ignored", outLine, 1);

    // reload with new count
    m = 10 + int'($urandom % 20);
    wrData(m[7:0]);
    chkEq("R3 half-written count no effect", outLine, 1);
    wrData(m[15:8]);
    chkEq("R4 new count drives low", outLine, 0);
    doTick(); doTick();
    gate = 1'b0;
    repeat (5) doTick();
    latchRead(v);
    chkEq("R5 gate low holds count", {16'b0, v}, m - 2);
    gate = 1'b1;
    doTick();
    latchRead(v);
    chkEq("R5 resume after gate", {16'b0, v}, m - 3);

    // latch while counting continues
    wrCtrl(8'h00);
    repeat (3) doTick();
    readWord(v);
    chkEq("R9 latch holds old value", {16'b0, v}, m - 3);
    latchRead(v);
    chkEq("R9 count kept running", {16'b0, v}, m - 6);
    wrCtrl(8'h00);
    doTick();
    wrCtrl(8'h00);
    readWord(v);
    chkEq("R9 second latch ignored", {16'b0, v}, m - 6);
    readWord(v);
    chkEq("R10 live read", {16'b0, v}, m - 7);

    // access modes and zero count
    wrCtrl(8'h10);
    chkEq("R2 idle after new word", outLine, 0);
    wrData(8'h05);
    doTick();
    readByte(b);
    chkEq("R3 LSB-only read", {24'b0, b}, 4);
    repeat (3) doTick();
    chkEq("R3 LSB-only high byte zero", outLine, 0);
    doTick();
    chkEq("R3 LSB-only expiry", outLine, 1);
    wrCtrl(8'h20);
    wrData(8'h01);
    doTick();
    readByte(b);
    chkEq("R3 MSB-only low byte zero", {24'b0, b}, 0);
    wrCtrl(8'h30);
    wrData(8'h00); wrData(8'h00);
    doTick();
    latchRead(v);
    chkEq("R3 zero acts as 65536", {16'b0, v}, 16'hFFFF);
    chkEq("R3 zero count not expired", outLine, 0);

    // rate generator
    for (int rep = 0; rep < 2; rep++) begin
      wrCtrl(8'h34);
      chkEq("R2 rate idle high", outLine, 1);
      n = 3 + int'($urandom % 10);
      wrData(n[7:0]); wrData(n[15:8]);
      for (int k = 1; k <= 3 * n; k++) begin
        doTick();
        chkEq("R6 rate waveform", outLine, rateOut(k, n));
      end
      gate = 1'b0;
      repeat (4) doTick();
      latchRead(v);
      chkEq("R5 rate gate hold", {16'b0, v}, n);
      gate = 1'b1;
    end

    // one-shot
    for (int rep = 0; rep < 2; rep++) begin
      gate = 1'b0;
      wrCtrl(8'h32);
      chkEq("R2 one-shot idle high", outLine, 1);
      n = 3 + int'($urandom % 12);
      wrData(n[7:0]); wrData(n[15:8]);
      repeat (3) doTick();
      chkEq("R7 no start without trigger", outLine, 1);
      setGate(1'b1);
      chkEq("R7 trigger drives low", outLine, 0);
      for (int k = 1; k <= n; k++) begin
        doTick();
        chkEq("R7 pulse width", outLine, (k == n) ? 1 : 0);
      end
      setGate(1'b0);
      setGate(1'b1);
      doTick(); doTick();
      setGate(1'b0);
      setGate(1'b1);
      for (int k = 1; k <= n; k++) begin
        doTick();
        chkEq("R8 retrigger restarts", outLine, (k == n) ? 1 : 0);
      end
      m = 3 + int'($urandom % 12);
      setGate(1'b0);
      setGate(1'b1);
      doTick();
      wrData(m[7:0]); wrData(m[15:8]);
      for (int k = 2; k <= n; k++) begin
        doTick();
        chkEq("R8 mid-pulse write deferred", outLine, (k == n) ? 1 : 0);
      end
      setGate(1'b0);
      setGate(1'b1);
      for (int k = 1; k <= m; k++) begin
        doTick();
        chkEq("R8 new count on next trigger", outLine, (k == m) ? 1 : 0);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule